// File: doc/BRIEF.md
# Temperature-Scaled Self-Discharge Decrementer

This block holds a 16-bit available-capacity register and models the charge a battery loses on its own while idle. On every pulse of a day-fraction tick it removes a power-of-two fraction of the present value. A 3-bit temperature bin picks that fraction, and so does a two-bit rate-select code. The loss doubles for each warmer 10°C bin. The slowest case removes capacity/2048 in the coldest bin. The fastest case removes capacity/2 above 70°C.

A charge-complete level from a charger overrides the decay. While it is high, the register copies the full-capacity input each cycle, and a qualified flag goes to 1. The flag stays at 1 until reset. A small controller with three states tracks this: ST_EMPTY (after reset, flag 0), ST_FULL (charge-complete high) and ST_TRACK (decaying after a charge). It has these transitions:
- T_CHARGE: ST_EMPTY→ST_FULL on done.
- T_RELEASE: ST_FULL→ST_TRACK when done falls.
- T_RECHARGE: ST_TRACK→ST_FULL on done.

Every other case holds the state. Outputs are registered and change on the clock edge after the input that causes the change.

Top module: `sdc_decrementer`

## Requirements
- R1: After reset, cap_o is 0 and dq_o is 0.
- R2: When done_i is high at a clock edge, the next cap_o equals full_cap_i and dq_o is 1.
- R3: When done_i and day_tick_i are both high, done_i wins and no decrement is applied (cap_o equals full_cap_i).
- R4: With done_i low and day_tick_i high, cap_o becomes cap_o − (cap_o >> s), with s = base − temp_bin_i. For rate_sel_i = 00 (fast), base is 8. So each warmer bin halves the divisor: from 256 at bin 0 down to 2 at bin 7.
- R5: rate_sel_i = 01 (middle) uses base 9, giving divisors 512 to 4. rate_sel_i = 10 (slow) uses base 11, giving divisors 2048 to 16. Code 11 is treated as middle.
- R6: With done_i and day_tick_i both low, cap_o holds its value.
- R7: The decrement never takes cap_o below zero or above its previous value. When cap_o >> s is 0, a tick leaves cap_o unchanged.
- R8: While done_i stays high, cap_o follows full_cap_i on every cycle, including changes of full_cap_i.
- R9: Once set, dq_o stays 1 after done_i falls, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| temp_bin_i | input | 3 | Temperature bin, 0 = below 10°C … 7 = above 70°C |
| rate_sel_i | input | 2 | Rate select: 00 fast, 01 middle, 10 slow, 11 middle |
| day_tick_i | input | 1 | One-cycle decay pulse |
| done_i | input | 1 | Charge-complete level |
| full_cap_i | input | 16 | Full-capacity value |
| cap_o | output | 16 | Available capacity |
| dq_o | output | 1 | Discharge-qualified flag |

## Verification
The assertions check on every cycle that done_i loads full_cap_i and sets the flag, that cap_o holds without a tick, that a tick never raises cap_o or removes more than half of it, and that the flag never clears. Only the bench's scenarios can show the exact amount removed for each temperature bin and rate code, including the alias code 11. The same goes for the point at which small values stop decaying, and for the exact precedence when done and a tick arrive together.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    typedef enum logic [1:0] {
        RATE_FAST = 2'b00,
        RATE_MID  = 2'b01,
        RATE_SLOW = 2'b10,
        RATE_ALT  = 2'b11
    } rate_e;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'b00,
        ST_FULL  = 2'b01,
        ST_TRACK = 2'b10
    } state_e;

endpackage

// File: rtl/sdc_shift_sel.sv
module sdc_shift_sel
    import sdc_pkg::*;
#(
    parameter int TEMP_W    = 3,
    parameter int SHIFT_W   = 4,
    parameter int FAST_BASE = 8,
    parameter int MID_BASE  = 9,
    parameter int SLOW_BASE = 11
) (
    input  logic [TEMP_W-1:0]  temp_i,
    input  logic [1:0]         rate_i,
    output logic [SHIFT_W-1:0] shift_o
);
    localparam logic [SHIFT_W-1:0] FAST_S = SHIFT_W'(FAST_BASE);
    localparam logic [SHIFT_W-1:0] MID_S  = SHIFT_W'(MID_BASE);
    localparam logic [SHIFT_W-1:0] SLOW_S = SHIFT_W'(SLOW_BASE);

    logic [SHIFT_W-1:0] base;
    logic [SHIFT_W-1:0] temp_ext;

    always_comb begin
        unique case (rate_e'(rate_i))
            RATE_FAST: base = FAST_S;
            RATE_MID:  base = MID_S;
            RATE_SLOW: base = SLOW_S;
            RATE_ALT:  base = MID_S;
            default:   base = MID_S;
        endcase
    end

    assign temp_ext = SHIFT_W'(temp_i);

    // A warmer bin than the base allows saturates at shift zero.
    assign shift_o = (temp_ext > base) ? '0 : base - temp_ext;

endmodule

// File: rtl/sdc_decay_unit.sv
module sdc_decay_unit #(
    parameter int CAP_W   = 16,
    parameter int SHIFT_W = 4
) (
    input  logic [CAP_W-1:0]   cap_i,
    input  logic [SHIFT_W-1:0] shift_i,
    output logic [CAP_W-1:0]   cap_o
);
    logic [CAP_W-1:0] loss;

    assign loss  = cap_i >> shift_i;
    assign cap_o = (loss > cap_i) ? '0 : cap_i - loss;

endmodule

// File: rtl/sdc_ctrl_fsm.sv
module sdc_ctrl_fsm
    import sdc_pkg::*;
#(
    parameter int CAP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done_i,
    input  logic             tick_i,
    input  logic [CAP_W-1:0] full_i,
    input  logic [CAP_W-1:0] decayed_i,
    output logic [CAP_W-1:0] cap_o,
    output logic             dq_o
);
    state_e state_q, state_d;
    logic [CAP_W-1:0] cap_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // Transitions: T_CHARGE, T_RELEASE, T_RECHARGE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (done_i)  state_d = ST_FULL;
            ST_FULL:  if (!done_i) state_d = ST_TRACK;
            ST_TRACK: if (done_i)  state_d = ST_FULL;
            default:               state_d = ST_EMPTY;
        endcase
    end

    // Capacity register: charge-complete has priority over a tick
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cap_q <= '0;
        else if (done_i) cap_q <= full_i;
        else if (tick_i) cap_q <= decayed_i;
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_EMPTY: dq_o = 1'b0;
            ST_FULL:  dq_o = 1'b1;
            ST_TRACK: dq_o = 1'b1;
            default:  dq_o = 1'b0;
        endcase
    end

    assign cap_o = cap_q;

endmodule

// File: rtl/sdc_decrementer.sv
module sdc_decrementer #(
    parameter int CAP_W     = 16,
    parameter int TEMP_W    = 3,
    parameter int FAST_BASE = 8,
    parameter int MID_BASE  = 9,
    parameter int SLOW_BASE = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp_bin_i,
    input  logic [1:0]        rate_sel_i,
    input  logic              day_tick_i,
    input  logic              done_i,
    input  logic [CAP_W-1:0]  full_cap_i,
    output logic [CAP_W-1:0]  cap_o,
    output logic              dq_o
);
    localparam int SHIFT_W = $clog2(SLOW_BASE + 1);

    logic [SHIFT_W-1:0] shift;
    logic [CAP_W-1:0]   decayed;

    sdc_shift_sel #(
        .TEMP_W(TEMP_W), .SHIFT_W(SHIFT_W),
        .FAST_BASE(FAST_BASE), .MID_BASE(MID_BASE), .SLOW_BASE(SLOW_BASE)
    ) i_shift (
        .temp_i(temp_bin_i), .rate_i(rate_sel_i), .shift_o(shift)
    );

    sdc_decay_unit #(.CAP_W(CAP_W), .SHIFT_W(SHIFT_W)) i_decay (
        .cap_i(cap_o), .shift_i(shift), .cap_o(decayed)
    );

    sdc_ctrl_fsm #(.CAP_W(CAP_W)) i_fsm (
        .clk(clk), .rst_n(rst_n), .done_i(done_i), .tick_i(day_tick_i),
        .full_i(full_cap_i), .decayed_i(decayed), .cap_o(cap_o), .dq_o(dq_o)
    );

endmodule

// File: rtl/sdc_decrementer_chk.sv
module sdc_decrementer_chk #(
    parameter int CAP_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             done_i,
    input logic             day_tick_i,
    input logic [CAP_W-1:0] full_cap_i,
    input logic [CAP_W-1:0] cap_o,
    input logic             dq_o
);
    a_r2_done_loads: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> (cap_o == $past(full_cap_i)) && dq_o);

    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_i && !day_tick_i) |=> $stable(cap_o));

    a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_i && day_tick_i) |=> (cap_o <= $past(cap_o)));

    a_r4_at_most_half: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_i && day_tick_i) |=> (cap_o >= ($past(cap_o) >> 1)));

    a_r9_dq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        dq_o |=> dq_o);

endmodule

bind sdc_decrementer sdc_decrementer_chk #(.CAP_W(CAP_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .done_i(done_i), .day_tick_i(day_tick_i),
    .full_cap_i(full_cap_i), .cap_o(cap_o), .dq_o(dq_o)
);

// File: tb/test_sdc_decrementer.sv
`timescale 1ns/1ps
module test_sdc_decrementer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  temp_bin = '0;
    logic [1:0]  rate_sel = '0;
    logic        tick = 1'b0;
    logic        done = 1'b0;
    logic [15:0] full = '0;
    logic [15:0] cap;
    logic        dq;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [15:0] m_cap = '0;
    logic        m_dq  = 1'b0;

    logic [16:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    sdc_decrementer i_sdc_decrementer (
        .clk(clk), .rst_n(rst_n), .temp_bin_i(temp_bin), .rate_sel_i(rate_sel),
        .day_tick_i(tick), .done_i(done), .full_cap_i(full), .cap_o(cap), .dq_o(dq)
    );

    function automatic int base_of(input logic [1:0] r);
        case (r)
            2'b00:   return 8;
            2'b10:   return 11;
            default: return 9;
        endcase
    endfunction

    // Driver: applies one cycle of stimulus and pushes the expected result
    task automatic step(input logic d, input logic t, input logic [2:0] tb,
                        input logic [1:0] r, input logic [15:0] f, input string tag);
        @(negedge clk);
        done = d; tick = t; temp_bin = tb; rate_sel = r; full = f;
        if (d) begin
            m_cap = f; m_dq = 1'b1;
        end else if (t) begin
            m_cap = m_cap - (m_cap >> (base_of(r) - int'(tb)));
        end
        exp_q.push_back({m_dq, m_cap});
        tag_q.push_back(tag);
    endtask

    // Monitor: compares after each edge
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            logic [16:0] e;
            string tg;
            e = exp_q.pop_front();
            tg = tag_q.pop_front();
            n_cmp++;
            if ({dq, cap} !== e) begin
                n_bad++;
                $display("FAIL %s cap=%h dq=%b expected cap=%h dq=%b",
                         tg, cap, dq, e[15:0], e[16]);
            end
        end
    end

    task automatic check_reset(input string tag);
        n_cmp++;
        if (cap !== 16'h0 || dq !== 1'b0) begin
            n_bad++;
            $display("FAIL %s cap=%h dq=%b expected cap=0000 dq=0", tag, cap, dq);
        end
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_reset("R1 after release");

        // R2: charge-complete loads full value and sets the flag
        step(1, 0, 0, 2'b00, 16'h8000, "R2 load");
        // R4 fast, bin 0 and bin 7
        step(0, 1, 0, 2'b00, 16'h0000, "R4 fast bin0");
        step(0, 1, 7, 2'b00, 16'h0000, "R4 fast bin7");
        step(0, 1, 3, 2'b00, 16'h0000, "R4 fast bin3");
        // R6 idle cycles hold
        step(0, 0, 7, 2'b00, 16'h1234, "R6 hold");
        step(0, 0, 2, 2'b10, 16'hFFFF, "R6 hold");
        // R9 flag stays set
        step(0, 0, 0, 2'b01, 16'h0000, "R9 sticky");
        // R3 done beats tick
        step(1, 1, 7, 2'b00, 16'hF000, "R3 done over tick");
        // R8 follow full while done high
        step(1, 0, 0, 2'b00, 16'hABCD, "R8 follow");
        step(1, 1, 4, 2'b10, 16'h0FF0, "R8 follow");
        // R5 middle, slow, alias code
        step(0, 1, 0, 2'b01, 16'h0000, "R5 mid bin0");
        step(0, 1, 7, 2'b01, 16'h0000, "R5 mid bin7");
        step(0, 1, 0, 2'b10, 16'h0000, "R5 slow bin0");
        step(0, 1, 7, 2'b10, 16'h0000, "R5 slow bin7");
        step(0, 1, 5, 2'b11, 16'h0000, "R5 alias mid");
        // R7 small values stop at a floor
        step(1, 0, 0, 2'b00, 16'h0003, "R2 load small");
        step(0, 1, 7, 2'b00, 16'h0000, "R7 small");
        step(0, 1, 7, 2'b00, 16'h0000, "R7 small");
        step(0, 1, 7, 2'b00, 16'h0000, "R7 floor");
        step(0, 1, 0, 2'b10, 16'h0000, "R7 floor");
        step(1, 0, 0, 2'b00, 16'h0000, "R2 load zero");
        step(0, 1, 7, 2'b00, 16'h0000, "R7 zero");
        // Mixed patterns
        step(1, 0, 0, 2'b00, 16'hFFFF, "R2 load max");
        for (int i = 0; i < 300; i++) begin
            logic d;
            d = ($urandom_range(0, 19) == 0);
            step(d, 1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)),
                 2'($urandom_range(0, 3)), 16'($urandom()), "R4 R5 mixed");
        end
        repeat (3) @(negedge clk);
        // R1 again after a second reset
        rst_n = 1'b0;
        #3;
        check_reset("R1 second reset");
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule